// File: doc/BRIEF.md
# FIFO-Buffered SPI Master Controller

This block is a full-duplex serial master that a processor drives through a small register bus. Software sets a half-period divider and a control word, then pushes words into an 8-entry transmit queue. The shift engine pulls each queued word and clocks it out on `sck`/`mosi` while sampling `miso`. Each finished word goes into an 8-entry receive queue, which software drains by reading the receive register. When the transmit queue is empty and the engine is idle, an interrupt line can be raised to tell software that the batch is complete. Chip select is driven outside this block.

The serial engine is a three-state machine. `ENG_IDLE` holds `sck` at the polarity level. On *start* (master and enable set, soft reset clear, transmit queue not empty) it loads a word and moves to `ENG_LEAD`. When the half-period count expires, the *lead-edge* transition toggles `sck` and moves to `ENG_TRAIL`. The next expiry is the *trail-edge* transition. If bits remain, or if another word is queued and the engine may run, it returns to `ENG_LEAD`; this is the *continue* or *chain* transition. Otherwise the *finish* transition returns it to `ENG_IDLE`. A soft reset forces *abort* to `ENG_IDLE` from any state.

Word width runs from 2 to 16 bits. The block supports both clock polarities and both phases, either bit order, and an internal loopback. Divider values below 7 are outside the supported range.

Top module: `spi_fifo_master`

## Requirements
- R1: Register offsets are 0x00 divider, 0x04 transmit data (write), 0x08 receive data (read), 0x0C control, 0x10 interrupt enable. Each read at 0x08 returns the oldest received word right-aligned in 16 bits and removes it. A read of an empty receive queue returns 0.
- R2: Each `sck` half period lasts exactly D clock cycles, where D is the divider value and a value of 0 means 65536. The first edge of a transfer comes D+1 cycles after the transmit write is taken.
- R3: Control bits [3:0] hold the word width minus one, so 0xF gives 16-bit words. Transmit bits above the width are ignored.
- R4: Control bit 6 sets the idle level of `sck`. With control bit 5 at 0, data is sampled on the first edge of each bit and changes on the second edge. With bit 5 at 1, data changes on the first edge and is sampled on the second edge. Each word produces exactly twice its width in `sck` edges.
- R5: Control bit 4 at 1 sends and assembles the most significant bit first. At 0, the least significant bit goes first.
- R6: Control bit 10 routes `mosi` back into the sampler in place of the `miso` pin.
- R7: The transmit queue holds 8 words, and a write to it while full is dropped. With control bit 11 at 0, transmit writes are ignored.
- R8: The receive queue holds 8 words. A word finished while the queue is full is discarded and sets the sticky `rx_overrun` output. With control bit 12 at 0, finished words are discarded and `rx_overrun` is not set.
- R9: `irq` is high exactly when interrupt-enable bit 2 is set, the transmit queue is empty and the engine is idle. Writing 0 to the interrupt-enable register masks it.
- R10: While control bit 7 is set, both queues, the engine, the divider count and `rx_overrun` are cleared, and `sck` goes to the idle level.
- R11: Words are shifted only while control bits 8 (master) and 9 (enable) are both set. Queued words follow one another with no gap, keeping the half-period spacing across word boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive queue at 0x08) |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (receive queue head at 0x08, else 0) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Transmit-drained interrupt |
| rx_overrun | output | 1 | Sticky receive overflow flag |

## Verification
The bench plays an external SPI slave in all four polarity/phase modes and in both bit orders. A design that sampled on the wrong edge, or that drove the first bit late in phase 0, would receive a shifted or corrupted word, and the slave would capture the wrong `mosi` bits. It times edges across a two-word burst and with a divider of 0. An off-by-one in the half-period count, a gap at word boundaries, or treating 0 as a tiny divider would show up as mismatched edge times. It overfills both queues and disables each queue in turn. A design that let a ninth write through, overwrote the oldest received word, or flagged overrun while reception was disabled would return the wrong word sequence or flag. A soft reset is applied with words still queued, so a design that kept stale transmit data would emit edges afterwards.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    localparam int ADDR_W     = 5;
    localparam int WORD_W     = 16;
    localparam int DIV_W      = 16;
    localparam int FIFO_DEPTH = 8;
    localparam int CTL_W      = 13;

    localparam logic [ADDR_W-1:0] OFF_DIV  = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_TXD  = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_RXD  = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_CTL  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_IEN  = 5'h10;

    localparam int CB_MSB  = 4;
    localparam int CB_CPHA = 5;
    localparam int CB_CPOL = 6;
    localparam int CB_SRST = 7;
    localparam int CB_MSTR = 8;
    localparam int CB_RUN  = 9;
    localparam int CB_LOOP = 10;
    localparam int CB_TXQ  = 11;
    localparam int CB_RXQ  = 12;

    localparam int IE_DRAIN = 2;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_LEAD  = 2'd1,
        ENG_TRAIL = 2'd2
    } eng_state_e;

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             pop_ok, push_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign dout    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wr_ptr] <= din;
    end

    // R7 / R8: occupancy never passes the depth
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R1: popping an empty queue leaves it empty
    assert_empty_pop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_fifo_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DIV_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      srst,
    input  logic                      run_ok,
    input  logic [DIV_W-1:0]          div_val,
    input  logic [$clog2(WORD_W)-1:0] wlen_m1,
    input  logic                      msb_first,
    input  logic                      cpha,
    input  logic                      cpol,
    input  logic                      loopback,
    input  logic                      tx_avail,
    input  logic [WORD_W-1:0]         tx_word,
    output logic                      tx_take,
    output logic [WORD_W-1:0]         rx_word,
    output logic                      rx_push,
    output logic                      idle,
    output logic                      sck,
    output logic                      mosi,
    input  logic                      miso
);
    localparam int IDX_W = $clog2(WORD_W);
    localparam int CNT_W = DIV_W + 1;

    eng_state_e        state_q, state_d;
    logic [CNT_W-1:0]  half_len, div_q;
    logic [IDX_W-1:0]  bit_q;
    logic [WORD_W-1:0] txw_q, rxw_q, rx_next;
    logic              sck_q, mosi_q;
    logic              tick, last_bit, go, din, sample_now;

    function automatic logic [IDX_W-1:0] bit_pos(input logic [IDX_W-1:0] k,
                                                 input logic [IDX_W-1:0] top,
                                                 input logic msb);
        return msb ? (top - k) : k;
    endfunction

    assign half_len   = (div_val == '0) ? (CNT_W'(1) << DIV_W) : {1'b0, div_val};
    assign tick       = (state_q != ENG_IDLE) && (div_q == half_len - 1'b1);
    assign last_bit   = (bit_q == wlen_m1);
    assign go         = run_ok && tx_avail;
    assign din        = loopback ? mosi_q : miso;
    assign sample_now = tick && (((state_q == ENG_LEAD) && !cpha) ||
                                 ((state_q == ENG_TRAIL) && cpha));

    always_comb begin
        rx_next = rxw_q;
        if (sample_now) rx_next[bit_pos(bit_q, wlen_m1, msb_first)] = din;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE:  if (go)   state_d = ENG_LEAD;
            ENG_LEAD:  if (tick) state_d = ENG_TRAIL;
            ENG_TRAIL: if (tick) state_d = (!last_bit || go) ? ENG_LEAD : ENG_IDLE;
            default:             state_d = ENG_IDLE;
        endcase
        if (srst) state_d = ENG_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        tx_take = !srst && go &&
                  ((state_q == ENG_IDLE) || ((state_q == ENG_TRAIL) && tick && last_bit));
        rx_push = !srst && (state_q == ENG_TRAIL) && tick && last_bit;
        idle    = (state_q == ENG_IDLE);
        rx_word = rx_next;
        sck     = sck_q;
        mosi    = mosi_q;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            bit_q  <= '0;
            txw_q  <= '0;
            rxw_q  <= '0;
            sck_q  <= 1'b0;
            mosi_q <= 1'b0;
        end else if (srst) begin
            div_q  <= '0;
            bit_q  <= '0;
            txw_q  <= '0;
            rxw_q  <= '0;
            sck_q  <= cpol;
            mosi_q <= 1'b0;
        end else begin
            if (state_q == ENG_IDLE) begin
                sck_q <= cpol;
                div_q <= '0;
            end else if (tick) begin
                div_q <= '0;
                sck_q <= ~sck_q;
                rxw_q <= rx_next;
            end else begin
                div_q <= div_q + 1'b1;
            end
            if ((state_q == ENG_LEAD) && tick && cpha)
                mosi_q <= txw_q[bit_pos(bit_q, wlen_m1, msb_first)];
            if ((state_q == ENG_TRAIL) && tick && !last_bit) begin
                bit_q <= bit_q + 1'b1;
                if (!cpha) mosi_q <= txw_q[bit_pos(bit_q + 1'b1, wlen_m1, msb_first)];
            end
            if (tx_take) begin
                txw_q <= tx_word;
                bit_q <= '0;
                rxw_q <= '0;
                if (!cpha) mosi_q <= tx_word[bit_pos('0, wlen_m1, msb_first)];
            end
        end
    end

    // R10: soft reset leaves the engine idle with sck at the polarity level
    assert_srst_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (state_q == ENG_IDLE) && (sck_q == $past(cpol)));

    // R2: sck moves only when the half-period count expires
    assert_sck_paced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ENG_IDLE) && !tick && !srst) |=> $stable(sck_q));

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    parameter int DIVW  = DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              irq,
    output logic              rx_overrun
);
    localparam int IDX_W = $clog2(WORD_W);

    logic [DIVW-1:0]   div_q;
    logic [CTL_W-1:0]  ctl_q;
    logic              ien_q, ovr_q;

    logic              srst, run_ok;
    logic              tx_push, tx_pop, tx_full, tx_empty;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [WORD_W-1:0] tx_head, rx_head, eng_rx_word;
    logic              eng_rx_push, eng_idle;

    assign srst    = ctl_q[CB_SRST];
    assign run_ok  = ctl_q[CB_MSTR] && ctl_q[CB_RUN] && !srst;
    assign tx_push = bus_wr && (bus_addr == OFF_TXD) && ctl_q[CB_TXQ];
    assign rx_pop  = bus_rd && (bus_addr == OFF_RXD);
    assign rx_push = eng_rx_push && ctl_q[CB_RXQ];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            ctl_q <= '0;
            ien_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == OFF_DIV) div_q <= bus_wdata[DIVW-1:0];
            if (bus_wr && bus_addr == OFF_CTL) ctl_q <= bus_wdata[CTL_W-1:0];
            if (bus_wr && bus_addr == OFF_IEN) ien_q <= bus_wdata[IE_DRAIN];
            if (srst)                                  ovr_q <= 1'b0;
            else if (rx_push && rx_full && !rx_pop)    ovr_q <= 1'b1;
        end
    end

    spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(srst),
        .push(tx_push), .din(bus_wdata), .pop(tx_pop),
        .dout(tx_head), .full(tx_full), .empty(tx_empty)
    );

    spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(srst),
        .push(rx_push), .din(eng_rx_word), .pop(rx_pop),
        .dout(rx_head), .full(rx_full), .empty(rx_empty)
    );

    spi_shift_engine #(.WORD_W(WORD_W), .DIV_W(DIVW)) u_eng (
        .clk(clk), .rst_n(rst_n), .srst(srst), .run_ok(run_ok),
        .div_val(div_q), .wlen_m1(ctl_q[IDX_W-1:0]),
        .msb_first(ctl_q[CB_MSB]), .cpha(ctl_q[CB_CPHA]), .cpol(ctl_q[CB_CPOL]),
        .loopback(ctl_q[CB_LOOP]), .tx_avail(!tx_empty), .tx_word(tx_head),
        .tx_take(tx_pop), .rx_word(eng_rx_word), .rx_push(eng_rx_push),
        .idle(eng_idle), .sck(sck), .mosi(mosi), .miso(miso)
    );

    assign bus_rdata  = ((bus_addr == OFF_RXD) && !rx_empty) ? rx_head : '0;
    assign irq        = ien_q && tx_empty && eng_idle;
    assign rx_overrun = ovr_q;

    // R7: a write into a full transmit queue changes nothing
    assert_tx_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_full && !tx_pop && !srst) |=> tx_full);

    // R8: overrun only appears after a full receive queue
    assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(rx_full));

endmodule

// File: tb/spi_fifo_master_bench.sv
module spi_fifo_master_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sck, mosi, irq, rx_overrun;
    logic        miso = 1'b0;

    int n_chk = 0, n_fail = 0, cyc = 0;

    spi_fifo_master u_spi_fifo_master (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .irq(irq), .rx_overrun(rx_overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // slave model and edge timing
    int          n_edges = 0;
    time         first_t = 0, last_t = 0;
    logic        slv_on = 1'b0, s_cpol = 1'b0, s_cpha = 1'b0, s_msb = 1'b0;
    int          s_n = 8, s_edges = 0;
    logic [15:0] s_tx = '0, s_rx = '0;

    function automatic int spos(input int k, input int n, input logic msb);
        return msb ? (n - 1 - k) : k;
    endfunction

    always @(sck) begin
        if (rst_n) begin
            if (n_edges == 0) first_t = $time;
            last_t = $time;
            n_edges++;
        end
        if (slv_on) begin
            automatic logic lead = (sck !== s_cpol);
            automatic int   k = s_edges >> 1;
            if (lead ^ s_cpha) s_rx[spos(k, s_n, s_msb)] = mosi;
            else if (lead) miso = s_tx[spos(k, s_n, s_msb)];
            else if (k + 1 < s_n) miso = s_tx[spos(k + 1, s_n, s_msb)];
            s_edges++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    time t_wr = 0;

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        t_wr = $time;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(output logic [15:0] d);
        @(negedge clk);
        bus_addr = 5'h08; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (irq !== 1'b1 && n < 80000) begin
            @(negedge clk);
            n++;
        end
        chk(req, {31'd0, irq}, 32'd1);
    endtask

    function automatic logic [15:0] mk_ctl(input int wm1, input logic msb, input logic cpha,
                                           input logic cpol, input logic srst, input logic en,
                                           input logic loop, input logic txq, input logic rxq);
        return 16'(wm1 & 15) | (16'(msb) << 4) | (16'(cpha) << 5) | (16'(cpol) << 6) |
               (16'(srst) << 7) | (16'd1 << 8) | (16'(en) << 9) | (16'(loop) << 10) |
               (16'(txq) << 11) | (16'(rxq) << 12);
    endfunction

    function automatic logic [15:0] msk(input int n);
        return 16'((32'd1 << n) - 1);
    endfunction

    initial begin
        logic [15:0] d;
        logic [15:0] words [10];
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // reset state (R1, R9, R8, R4)
        chk("R4 reset sck", {31'd0, sck}, 0);
        chk("R9 reset irq", {31'd0, irq}, 0);
        chk("R8 reset overrun", {31'd0, rx_overrun}, 0);
        rst_n = 1'b1;
        rd(d);
        chk("R1 empty read", {16'd0, d}, 0);

        // interrupt masked then enabled (R9)
        wr(5'h10, 16'h0000);
        idle_cycles(2);
        chk("R9 masked irq", {31'd0, irq}, 0);
        wr(5'h10, 16'h0004);
        idle_cycles(1);
        chk("R9 enabled idle irq", {31'd0, irq}, 1);

        // random loopback batches (R3 R5 R6 R11)
        for (int it = 0; it < 20; it++) begin
            automatic int wm1 = 1 + int'($urandom % 15);
            automatic int cnt = 1 + int'($urandom % 8);
            wr(5'h00, 16'(7 + $urandom % 3));
            wr(5'h0C, mk_ctl(wm1, 1'($urandom), 1'($urandom), 1'($urandom), 0, 1, 1, 1, 1));
            for (int i = 0; i < cnt; i++) begin
                words[i] = 16'($urandom);
                wr(5'h04, words[i]);
            end
            chk("R9 busy irq low", {31'd0, irq}, 0);
            wait_irq("R9 drained irq");
            for (int i = 0; i < cnt; i++) begin
                rd(d);
                chk("R6 R3 R5 loopback word", {16'd0, d}, {16'd0, words[i] & msk(wm1 + 1)});
            end
            rd(d);
            chk("R1 drained read", {16'd0, d}, 0);
        end

        // external slave in all modes and orders (R4 R5)
        for (int m = 0; m < 8; m++) begin
            automatic int wm1 = 1 + int'($urandom % 15);
            automatic logic [15:0] tw = 16'($urandom);
            wr(5'h00, 16'd8);
            wr(5'h0C, mk_ctl(wm1, m[2], m[0], m[1], 0, 1, 0, 1, 1));
            idle_cycles(2);
            chk("R4 idle level", {31'd0, sck}, {31'd0, m[1]});
            s_cpha = m[0]; s_cpol = m[1]; s_msb = m[2]; s_n = wm1 + 1;
            s_tx = 16'($urandom) & msk(wm1 + 1);
            s_rx = '0; s_edges = 0;
            miso = m[0] ? 1'b0 : s_tx[spos(0, s_n, s_msb)];
            slv_on = 1'b1;
            wr(5'h04, tw);
            wait_irq("R4 slave irq");
            slv_on = 1'b0;
            rd(d);
            chk("R4 miso word", {16'd0, d}, {16'd0, s_tx});
            chk("R5 mosi word", {16'd0, s_rx}, {16'd0, tw & msk(wm1 + 1)});
            chk("R4 edge count", s_edges, 2 * s_n);
        end
        miso = 1'b0;

        // back-to-back timing (R11 R2)
        wr(5'h00, 16'd7);
        wr(5'h0C, mk_ctl(7, 1, 0, 0, 0, 1, 1, 1, 1));
        idle_cycles(2);
        n_edges = 0;
        wr(5'h04, 16'h00A5);
        begin
            automatic time t0 = t_wr;
            wr(5'h04, 16'h003C);
            wait_irq("R11 burst irq");
            chk("R11 edge total", n_edges, 32);
            chk("R2 first edge", 32'(first_t - t0), 32'(CLK_PERIOD/2 + 8 * CLK_PERIOD));
            chk("R11 no gap", 32'(last_t - first_t), 32'(31 * 7 * CLK_PERIOD));
        end
        rd(d); chk("R11 word0", {16'd0, d}, 32'h00A5);
        rd(d); chk("R11 word1", {16'd0, d}, 32'h003C);

        // transmit queue full drop, enable gating, overrun (R7 R11 R8)
        wr(5'h0C, mk_ctl(7, 1, 0, 0, 0, 0, 1, 1, 1));
        idle_cycles(2);
        n_edges = 0;
        for (int i = 0; i < 10; i++) begin
            words[i] = 16'(8'($urandom));
            wr(5'h04, words[i]);
        end
        idle_cycles(50);
        chk("R11 disabled no edges", n_edges, 0);
        wr(5'h0C, mk_ctl(7, 1, 0, 0, 0, 1, 1, 1, 1));
        wait_irq("R7 irq");
        chk("R7 eight words sent", n_edges, 8 * 16);
        chk("R8 no overrun yet", {31'd0, rx_overrun}, 0);
        wr(5'h04, 16'h00FF);
        wait_irq("R8 irq");
        chk("R8 overrun set", {31'd0, rx_overrun}, 1);
        for (int i = 0; i < 8; i++) begin
            rd(d);
            chk("R8 R7 kept order", {16'd0, d}, {16'd0, words[i]});
        end
        rd(d);
        chk("R8 ninth discarded", {16'd0, d}, 0);

        // soft reset with queued words (R10)
        wr(5'h0C, mk_ctl(7, 1, 0, 1, 0, 0, 1, 1, 1));
        for (int i = 0; i < 3; i++) wr(5'h04, 16'h0011);
        wr(5'h0C, mk_ctl(7, 1, 0, 1, 1, 0, 1, 1, 1));
        idle_cycles(2);
        chk("R10 overrun cleared", {31'd0, rx_overrun}, 0);
        chk("R10 sck idle", {31'd0, sck}, 1);
        n_edges = 0;
        wr(5'h0C, mk_ctl(7, 1, 0, 1, 0, 1, 1, 1, 1));
        idle_cycles(300);
        chk("R10 queue flushed", n_edges, 0);
        rd(d);
        chk("R10 rx flushed", {16'd0, d}, 0);

        // transmit queue disabled (R7)
        wr(5'h0C, mk_ctl(7, 1, 0, 0, 0, 1, 1, 0, 1));
        idle_cycles(2);
        n_edges = 0;
        wr(5'h04, 16'h0055);
        idle_cycles(300);
        chk("R7 disabled tx no edges", n_edges, 0);
        chk("R9 irq stays", {31'd0, irq}, 1);

        // receive queue disabled (R8)
        wr(5'h0C, mk_ctl(7, 1, 0, 0, 0, 1, 1, 1, 0));
        for (int i = 0; i < 9; i++) wr(5'h04, 16'h0033);
        wait_irq("R8 rxq off irq");
        rd(d);
        chk("R8 rxq off discards", {16'd0, d}, 0);
        chk("R8 rxq off no overrun", {31'd0, rx_overrun}, 0);

        // divider zero means 65536 (R2)
        wr(5'h00, 16'd0);
        wr(5'h0C, mk_ctl(1, 1, 0, 0, 0, 1, 1, 1, 1));
        idle_cycles(2);
        n_edges = 0;
        wr(5'h04, 16'h0002);
        begin
            automatic time t0 = t_wr;
            automatic int n = 0;
            while (n_edges == 0 && n < 70000) begin
                @(negedge clk);
                n++;
            end
            chk("R2 zero divider", 32'(first_t - t0), 32'(CLK_PERIOD/2 + 65537 * CLK_PERIOD));
        end
        wr(5'h0C, mk_ctl(1, 1, 0, 0, 1, 1, 1, 1, 1));
        wr(5'h0C, mk_ctl(1, 1, 0, 0, 0, 1, 1, 1, 1));
        idle_cycles(2);
        chk("R10 abort idle", {31'd0, sck}, 0);
        chk("R9 abort irq", {31'd0, irq}, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule